// File: doc/BRIEF.md
# Escalating Watchdog Timer with Guarded Reconfiguration

This block is a watchdog. Its counter advances only on cycles where a slow tick input is high. That tick is a synchronous enable, nominally at 128 kHz, taken from an oscillator separate from the system clock. Software keeps the counter away from its limit by pulsing a restart strobe. If it fails to do so, the block acts according to the enabled mode:

- it raises an interrupt flag;
- it issues a one-cycle system reset pulse; or
- it raises the flag first and resets the system if the limit is reached again while that flag is still pending.

Configuration arrives as field-wise register writes. The interrupt enable and the flag clear can be written at any time. Clearing the reset enable or altering the 4-bit limit select is protected by a two-step sequence:

1. A write that sets both the change-request bit and the reset-enable bit opens a short window.
2. A single follow-up write with the change-request bit clear then loads the new values.

A fuse input overlays the stored enables and forces plain reset mode. Two synchronous resets are provided:

- `por` (power-on) clears everything.
- `rst` (any system reset) clears the counter, the window, the flag and the interrupt enable. The reset enable and the limit select are retained, so a watchdog-caused reset keeps the watchdog armed.

Top module: `wdog_top`

## Requirements
- R1: With limit select code c (0..9), the action occurs on exactly the 2^(BASE_LOG2+c)-th clock edge with `tick` high after the edge that registered `restart`; edges with `tick` low do not advance the count.
- R2: Select codes 10 to 15 behave exactly like code 9.
- R3: `restart` clears the counter; a restart in the same cycle as the terminal tick suppresses that time-out and the count starts over.
- R4: Interrupt-only mode (`rd_irq_en`=1, `rd_rst_en`=0): a time-out sets `rd_flag` and drives `irq`, and never pulses `wd_reset`, however many further time-outs follow.
- R5: Reset-only mode (`rd_rst_en`=1, `rd_irq_en`=0): a time-out drives `wd_reset` high for exactly one clock cycle and leaves `rd_flag` unchanged.
- R6: Escalation mode (both enables 1): a time-out with `rd_flag` clear sets the flag without a reset; a time-out with the flag already set pulses `wd_reset`. An `irq_ack` in this mode clears both the flag and the interrupt enable, leaving reset-only mode.
- R7: The flag is cleared by a write with `wr_flag_clr`=1 or by `irq_ack`. A time-out that sets it in the same cycle as a clear wins. In interrupt-only mode `irq_ack` leaves `rd_irq_en` at 1.
- R8: A write with `wr_chg`=1 and `wr_rst_en`=1 opens a window covering the next WIN_CYC (4) clock edges. A write with `wr_chg`=0 inside that window loads `wr_rst_en` into the reset enable and `wr_sel` into the select. Such a write on the fifth edge or later changes neither field.
- R9: Outside the window, a write can set the reset enable but never clear it, and never changes the select. The interrupt enable follows `wr_irq_en` on every write. A write with `wr_chg`=1 and `wr_rst_en`=0 opens no window.
- R10: While `fuse_on`=1, `rd_rst_en` reads 1, `rd_irq_en` reads 0, and time-outs reset without setting the flag. Writes of `wr_irq_en`=1 are discarded. When the fuse drops, the stored reset enable is visible again and the interrupt enable reads 0.
- R11: `rst` clears the counter, the open window, the flag and the interrupt enable, and keeps the reset enable and the select. `por` clears all state to 0.
- R12: With both enables 0, the counter does not run, so no time-out occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous system reset, active high (keeps reset enable and select) |
| por | input | 1 | Synchronous power-on reset, active high (clears all) |
| tick | input | 1 | Slow-oscillator cycle enable |
| restart | input | 1 | Counter restart strobe |
| fuse_on | input | 1 | Forces reset-only mode while high |
| irq_ack | input | 1 | Interrupt acknowledge |
| wr_en | input | 1 | Control register write strobe |
| wr_chg | input | 1 | Write field: change-request bit |
| wr_rst_en | input | 1 | Write field: reset enable |
| wr_irq_en | input | 1 | Write field: interrupt enable |
| wr_flag_clr | input | 1 | Write field: 1 clears the flag |
| wr_sel | input | SEL_W | Write field: limit select code |
| rd_rst_en | output | 1 | Effective reset enable |
| rd_irq_en | output | 1 | Effective interrupt enable |
| rd_sel | output | SEL_W | Stored limit select code |
| rd_flag | output | 1 | Time-out interrupt flag |
| irq | output | 1 | Interrupt request (flag and interrupt enable) |
| wd_reset | output | 1 | One-cycle system reset request |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is a restart strobe and the tick that would complete the count. The bench counts edges from a restart and raises `restart` again exactly on the terminal edge. It then expects no flag right after that edge, no flag three edges later, and the flag on the fourth edge.

The second pair is a time-out that sets the flag and an acknowledge that clears it. The bench places `irq_ack` on the terminal edge and judges by the flag, which must read 1 afterwards.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Field-wise content of one control register write (select carried apart)
    typedef struct packed {
        logic chg;
        logic rst_en;
        logic irq_en;
        logic flag_clr;
    } wr_ctl_t;

    // Effective operating mode: {interrupt enable, reset enable}
    typedef enum logic [1:0] {
        WM_OFF = 2'b00,
        WM_RST = 2'b01,
        WM_IRQ = 2'b10,
        WM_ESC = 2'b11
    } wd_mode_e;

    function automatic wd_mode_e mode_of(input logic irq_on, input logic rst_on);
        return wd_mode_e'({irq_on, rst_on});
    endfunction

    // Reserved select codes fold onto the longest period
    function automatic int unsigned clamp_code(input int unsigned code, input int unsigned top);
        return (code > top) ? top : code;
    endfunction

endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
    import wdog_pkg::*;
#(
    parameter int WIN_CYC = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    por,
    input  logic    wr_en,
    input  wr_ctl_t wr,
    output logic    win_open,
    output logic    commit
);
    localparam int WW = $clog2(WIN_CYC + 1);

    logic [WW-1:0] win_q;
    logic          open_req;

    always_comb begin
        open_req = wr_en & wr.chg & wr.rst_en;
        win_open = (win_q != '0);
        commit   = wr_en & ~wr.chg & win_open;
    end

    always_ff @(posedge clk) begin
        if (rst || por) begin
            win_q <= '0;
        end else if (open_req) begin
            win_q <= WW'(WIN_CYC);
        end else if (commit) begin
            win_q <= '0;
        end else if (win_open) begin
            win_q <= win_q - 1'b1;
        end
    end

endmodule

// File: rtl/wdog_tmr.sv
module wdog_tmr
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int MAX_CODE  = 9,
    parameter int SEL_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             por,
    input  logic             run,
    input  logic             tick,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);
    localparam int CW = BASE_LOG2 + MAX_CODE;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_m1;
    logic          term;

    always_comb begin
        lim_m1 = {CW{1'b1}} >> (MAX_CODE - clamp_code(32'(sel), MAX_CODE));
        term   = (cnt_q >= lim_m1);
        expire = run & tick & ~restart & term;
    end

    always_ff @(posedge clk) begin
        if (rst || por || !run || restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= term ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             por,
    input  logic             fuse_on,
    input  logic             irq_ack,
    input  logic             wr_en,
    input  wr_ctl_t          wr,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             commit,
    input  logic             expire,
    output logic             run,
    output logic             rd_rst_en,
    output logic             rd_irq_en,
    output logic [SEL_W-1:0] rd_sel,
    output logic             rd_flag,
    output logic             irq,
    output logic             wd_reset
);
    logic             rst_en_q;
    logic             irq_en_q;
    logic             flag_q;
    logic             pulse_q;
    logic [SEL_W-1:0] sel_q;

    wd_mode_e mode;
    logic     fire_irq;
    logic     fire_rst;
    logic     flag_clr;
    logic     ack_drop;

    always_comb begin
        mode     = mode_of(irq_en_q & ~fuse_on, rst_en_q | fuse_on);
        fire_irq = 1'b0;
        fire_rst = 1'b0;
        if (expire) begin
            case (mode)
                WM_IRQ:  fire_irq = 1'b1;
                WM_RST:  fire_rst = 1'b1;
                WM_ESC:  begin
                    if (flag_q) fire_rst = 1'b1;
                    else        fire_irq = 1'b1;
                end
                default: ;
            endcase
        end
        flag_clr = irq_ack | (wr_en & wr.flag_clr);
        ack_drop = irq_ack & (mode == WM_ESC);
    end

    always_ff @(posedge clk) begin
        if (por) begin
            rst_en_q <= 1'b0;
            irq_en_q <= 1'b0;
            flag_q   <= 1'b0;
            pulse_q  <= 1'b0;
            sel_q    <= '0;
        end else if (rst) begin
            irq_en_q <= 1'b0;
            flag_q   <= 1'b0;
            pulse_q  <= 1'b0;
        end else begin
            pulse_q <= fire_rst;

            if (fire_irq)      flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;

            if (commit) begin
                rst_en_q <= wr.rst_en;
                sel_q    <= wr_sel;
            end else if (wr_en && wr.rst_en) begin
                rst_en_q <= 1'b1;
            end

            if (fuse_on)       irq_en_q <= 1'b0;
            else if (wr_en)    irq_en_q <= wr.irq_en;
            else if (ack_drop) irq_en_q <= 1'b0;
        end
    end

    always_comb begin
        run       = (mode != WM_OFF);
        rd_rst_en = rst_en_q | fuse_on;
        rd_irq_en = irq_en_q & ~fuse_on;
        rd_sel    = sel_q;
        rd_flag   = flag_q;
        irq       = flag_q & rd_irq_en;
        wd_reset  = pulse_q;
    end

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int MAX_CODE  = 9,
    parameter int WIN_CYC   = 4,
    parameter int SEL_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             por,
    input  logic             tick,
    input  logic             restart,
    input  logic             fuse_on,
    input  logic             irq_ack,
    input  logic             wr_en,
    input  logic             wr_chg,
    input  logic             wr_rst_en,
    input  logic             wr_irq_en,
    input  logic             wr_flag_clr,
    input  logic [SEL_W-1:0] wr_sel,
    output logic             rd_rst_en,
    output logic             rd_irq_en,
    output logic [SEL_W-1:0] rd_sel,
    output logic             rd_flag,
    output logic             irq,
    output logic             wd_reset
);
    wr_ctl_t wr;
    logic    win_open;
    logic    commit;
    logic    expire;
    logic    run;

    always_comb begin
        wr.chg      = wr_chg;
        wr.rst_en   = wr_rst_en;
        wr.irq_en   = wr_irq_en;
        wr.flag_clr = wr_flag_clr;
    end

    wdog_unlock #(.WIN_CYC(WIN_CYC)) u_unlock (
        .clk      (clk),
        .rst      (rst),
        .por      (por),
        .wr_en    (wr_en),
        .wr       (wr),
        .win_open (win_open),
        .commit   (commit)
    );

    wdog_tmr #(.BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE), .SEL_W(SEL_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .por     (por),
        .run     (run),
        .tick    (tick),
        .restart (restart),
        .sel     (rd_sel),
        .expire  (expire)
    );

    wdog_ctrl #(.SEL_W(SEL_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .por       (por),
        .fuse_on   (fuse_on),
        .irq_ack   (irq_ack),
        .wr_en     (wr_en),
        .wr        (wr),
        .wr_sel    (wr_sel),
        .commit    (commit),
        .expire    (expire),
        .run       (run),
        .rd_rst_en (rd_rst_en),
        .rd_irq_en (rd_irq_en),
        .rd_sel    (rd_sel),
        .rd_flag   (rd_flag),
        .irq       (irq),
        .wd_reset  (wd_reset)
    );

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             por,
    input logic             fuse_on,
    input logic             restart,
    input logic             rd_rst_en,
    input logic             rd_irq_en,
    input logic [SEL_W-1:0] rd_sel,
    input logic             rd_flag,
    input logic             wd_reset,
    input logic             win_open
);
    // R5
    reset_one_cycle_chk: assert property (@(posedge clk) disable iff (rst || por)
        wd_reset |=> !wd_reset);

    // R3
    restart_blocks_action_chk: assert property (@(posedge clk) disable iff (rst || por)
        restart |=> (!wd_reset && !$rose(rd_flag)));

    // R12
    idle_when_disabled_chk: assert property (@(posedge clk) disable iff (rst || por)
        (!rd_rst_en && !rd_irq_en) |=> (!wd_reset && !$rose(rd_flag)));

    // R10
    fuse_no_flag_chk: assert property (@(posedge clk) disable iff (rst || por)
        $rose(rd_flag) |-> !$past(fuse_on));

    // R6
    escalate_needs_flag_chk: assert property (@(posedge clk) disable iff (rst || por)
        (wd_reset && $past(rd_irq_en)) |-> $past(rd_flag));

    // R8
    sel_only_in_window_chk: assert property (@(posedge clk) disable iff (rst || por)
        (!$stable(rd_sel) && !$past(por)) |-> $past(win_open));

    // R9
    rst_en_clear_in_window_chk: assert property (@(posedge clk) disable iff (rst || por)
        ($fell(rd_rst_en) && !$past(por) && !$past(fuse_on)) |-> $past(win_open));

endmodule

bind wdog_top wdog_chk #(.SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .por       (por),
    .fuse_on   (fuse_on),
    .restart   (restart),
    .rd_rst_en (rd_rst_en),
    .rd_irq_en (rd_irq_en),
    .rd_sel    (rd_sel),
    .rd_flag   (rd_flag),
    .wd_reset  (wd_reset),
    .win_open  (win_open)
);

// File: tb/tb_wdog_top.sv
module tb_wdog_top;
    localparam int BASE = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       por = 1'b1;
    logic       tick = 1'b0;
    logic       restart = 1'b0;
    logic       fuse_on = 1'b0;
    logic       irq_ack = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_chg = 1'b0;
    logic       wr_rst_en = 1'b0;
    logic       wr_irq_en = 1'b0;
    logic       wr_flag_clr = 1'b0;
    logic [3:0] wr_sel = '0;
    logic       rd_rst_en;
    logic       rd_irq_en;
    logic [3:0] rd_sel;
    logic       rd_flag;
    logic       irq;
    logic       wd_reset;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    wdog_top #(.BASE_LOG2(BASE), .MAX_CODE(9), .WIN_CYC(4), .SEL_W(4)) dut (
        .clk(clk), .rst(rst), .por(por), .tick(tick), .restart(restart),
        .fuse_on(fuse_on), .irq_ack(irq_ack), .wr_en(wr_en), .wr_chg(wr_chg),
        .wr_rst_en(wr_rst_en), .wr_irq_en(wr_irq_en), .wr_flag_clr(wr_flag_clr),
        .wr_sel(wr_sel), .rd_rst_en(rd_rst_en), .rd_irq_en(rd_irq_en),
        .rd_sel(rd_sel), .rd_flag(rd_flag), .irq(irq), .wd_reset(wd_reset)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic idle_watch(input int n, output int pulses);
        pulses = 0;
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
            if (wd_reset) pulses++;
        end
    endtask

    task automatic do_wr(input logic chg, input logic re, input logic ie,
                         input logic fc, input logic [3:0] s);
        wr_en = 1'b1; wr_chg = chg; wr_rst_en = re; wr_irq_en = ie;
        wr_flag_clr = fc; wr_sel = s;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_chg = 1'b0; wr_rst_en = 1'b0; wr_flag_clr = 1'b0;
    endtask

    task automatic unlock_set(input logic re, input logic ie, input logic fc,
                              input logic [3:0] s);
        do_wr(1'b1, 1'b1, ie, 1'b0, s);
        do_wr(1'b0, re, ie, fc, s);
    endtask

    task automatic pulse_sig_rst();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_restart();
        restart = 1'b1;
        @(posedge clk);
        @(negedge clk);
        restart = 1'b0;
    endtask

    // Counts edges with tick high until the chosen event is seen
    task automatic measure(input bit rs, input bit on_flag, output int n);
        tick = 1'b1;
        if (rs) do_restart();
        n = 0;
        while (n < 6000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (on_flag ? rd_flag : wd_reset) break;
        end
        tick = 1'b0;
    endtask

    task automatic t_reset_state();
        chk("R11 por rst_en", rd_rst_en, 0);
        chk("R11 por irq_en", rd_irq_en, 0);
        chk("R11 por sel", rd_sel, 0);
        chk("R11 por flag", rd_flag, 0);
        chk("R11 por wd_reset", wd_reset, 0);
    endtask

    task automatic t_plain_writes();
        do_wr(1'b0, 1'b1, 1'b1, 1'b0, 4'd5);
        chk("R9 set rst_en", rd_rst_en, 1);
        chk("R9 irq_en free", rd_irq_en, 1);
        chk("R9 sel held", rd_sel, 0);
        do_wr(1'b0, 1'b0, 1'b0, 1'b0, 4'd7);
        chk("R9 no clear rst_en", rd_rst_en, 1);
        chk("R9 irq_en cleared", rd_irq_en, 0);
        do_wr(1'b1, 1'b0, 1'b0, 1'b0, 4'd7);
        do_wr(1'b0, 1'b0, 1'b0, 1'b0, 4'd7);
        chk("R9 no window sel", rd_sel, 0);
        chk("R9 no window rst_en", rd_rst_en, 1);
    endtask

    task automatic t_unlock();
        do_wr(1'b1, 1'b1, 1'b0, 1'b0, 4'd0);
        idle(3);
        do_wr(1'b0, 1'b0, 1'b0, 1'b0, 4'd6);
        chk("R8 4th edge rst_en", rd_rst_en, 0);
        chk("R8 4th edge sel", rd_sel, 6);
        do_wr(1'b1, 1'b1, 1'b0, 1'b0, 4'd0);
        chk("R8 open sets rst_en", rd_rst_en, 1);
        idle(4);
        do_wr(1'b0, 1'b0, 1'b0, 1'b0, 4'd3);
        chk("R8 late sel", rd_sel, 6);
        chk("R8 late rst_en", rd_rst_en, 1);
    endtask

    task automatic t_reset_mode();
        int n;
        unlock_set(1'b1, 1'b0, 1'b0, 4'd0);
        measure(1'b1, 1'b0, n);
        chk("R1 code0 edges", n, 4);
        chk("R5 flag untouched", rd_flag, 0);
        idle(1);
        chk("R5 one cycle", wd_reset, 0);
        unlock_set(1'b1, 1'b0, 1'b0, 4'd3);
        measure(1'b1, 1'b0, n);
        chk("R1 code3 edges", n, 32);
        unlock_set(1'b1, 1'b0, 1'b0, 4'd9);
        measure(1'b1, 1'b0, n);
        chk("R2 code9 edges", n, 2048);
        unlock_set(1'b1, 1'b0, 1'b0, 4'd12);
        measure(1'b1, 1'b0, n);
        chk("R2 code12 edges", n, 2048);
        unlock_set(1'b1, 1'b0, 1'b0, 4'd15);
        measure(1'b1, 1'b0, n);
        chk("R2 code15 edges", n, 2048);
    endtask

    task automatic t_tick_gate();
        int p;
        int total;
        unlock_set(1'b1, 1'b0, 1'b0, 4'd0);
        do_restart();
        total = 0;
        for (int i = 0; i < 3; i++) begin
            tick = 1'b1;
            idle_watch(1, p);
            total += p;
            tick = 1'b0;
            idle_watch(6, p);
            total += p;
        end
        chk("R1 three sparse ticks", total, 0);
        tick = 1'b1;
        idle(1);
        tick = 1'b0;
        chk("R1 fourth sparse tick", wd_reset, 1);
    endtask

    task automatic t_irq_mode();
        int n;
        int p;
        unlock_set(1'b0, 1'b1, 1'b1, 4'd0);
        measure(1'b1, 1'b1, n);
        chk("R4 flag edges", n, 4);
        chk("R4 irq out", irq, 1);
        tick = 1'b1;
        idle_watch(20, p);
        tick = 1'b0;
        chk("R4 no reset", p, 0);
        chk("R4 flag held", rd_flag, 1);
        do_wr(1'b0, 1'b0, 1'b1, 1'b1, 4'd0);
        chk("R7 write clear", rd_flag, 0);
        chk("R7 irq low", irq, 0);
        tick = 1'b1;
        do_restart();
        idle(3);
        irq_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        irq_ack = 1'b0;
        tick = 1'b0;
        chk("R7 set beats ack", rd_flag, 1);
        irq_ack = 1'b1;
        idle(1);
        irq_ack = 1'b0;
        chk("R7 ack clears", rd_flag, 0);
        chk("R7 irq_en kept", rd_irq_en, 1);
    endtask

    task automatic t_restart_race();
        tick = 1'b1;
        do_restart();
        idle(3);
        restart = 1'b1;
        @(posedge clk);
        @(negedge clk);
        restart = 1'b0;
        chk("R3 race suppressed", rd_flag, 0);
        idle(3);
        chk("R3 count restarted", rd_flag, 0);
        idle(1);
        tick = 1'b0;
        chk("R3 fires after full count", rd_flag, 1);
        irq_ack = 1'b1;
        idle(1);
        irq_ack = 1'b0;
    endtask

    task automatic t_escalate();
        int n;
        unlock_set(1'b1, 1'b1, 1'b1, 4'd0);
        measure(1'b1, 1'b0, n);
        chk("R6 reset on second timeout", n, 8);
        chk("R6 flag pending", rd_flag, 1);
        irq_ack = 1'b1;
        idle(1);
        irq_ack = 1'b0;
        chk("R6 ack clears flag", rd_flag, 0);
        chk("R6 ack drops irq_en", rd_irq_en, 0);
        chk("R6 rst_en stays", rd_rst_en, 1);
        measure(1'b1, 1'b0, n);
        chk("R6 then plain reset", n, 4);
        chk("R6 no flag after ack", rd_flag, 0);
    endtask

    task automatic t_fuse();
        int n;
        unlock_set(1'b0, 1'b1, 1'b0, 4'd0);
        fuse_on = 1'b1;
        #1;
        chk("R10 rst_en forced", rd_rst_en, 1);
        chk("R10 irq_en forced", rd_irq_en, 0);
        measure(1'b1, 1'b0, n);
        chk("R10 reset edges", n, 4);
        chk("R10 no flag", rd_flag, 0);
        do_wr(1'b0, 1'b0, 1'b1, 1'b0, 4'd0);
        chk("R10 irq write discarded", rd_irq_en, 0);
        fuse_on = 1'b0;
        #1;
        chk("R10 stored rst_en", rd_rst_en, 0);
        chk("R10 irq_en after fuse", rd_irq_en, 0);
    endtask

    task automatic t_sysrst();
        int n;
        unlock_set(1'b1, 1'b1, 1'b1, 4'd2);
        do_wr(1'b1, 1'b1, 1'b1, 1'b0, 4'd0);
        pulse_sig_rst();
        chk("R11 rst irq_en", rd_irq_en, 0);
        chk("R11 rst keeps rst_en", rd_rst_en, 1);
        chk("R11 rst keeps sel", rd_sel, 2);
        do_wr(1'b0, 1'b0, 1'b0, 1'b0, 4'd5);
        chk("R11 window closed sel", rd_sel, 2);
        chk("R11 window closed rst_en", rd_rst_en, 1);
        tick = 1'b1;
        idle(2);
        pulse_sig_rst();
        measure(1'b0, 1'b0, n);
        chk("R11 rst clears counter", n, 16);
    endtask

    task automatic t_disabled();
        int p;
        por = 1'b1;
        idle(2);
        por = 1'b0;
        t_reset_state();
        tick = 1'b1;
        idle_watch(100, p);
        tick = 1'b0;
        chk("R12 no reset", p, 0);
        chk("R12 no flag", rd_flag, 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        @(negedge clk);
        idle(3);
        por = 1'b0;
        idle(1);
        t_reset_state();
        t_plain_writes();
        t_unlock();
        t_reset_mode();
        t_tick_gate();
        t_irq_mode();
        t_restart_race();
        t_escalate();
        t_fuse();
        t_sysrst();
        t_disabled();
        summary();
    end

endmodule